// File: doc/BRIEF.md
# Reset and Boot Configuration Sequencer

This block runs the bring-up sequence of a switch device after the active-low fundamental reset is released. On the first clock edge after release it captures the strap pins once. It builds the 7-bit management-bus slave address and the 7-bit EEPROM address from sampled pins and fixed constant bits, latches the speed strap of the master bus, and decodes the boot-mode strap.

When the boot mode asks for it, the block raises a configuration-load request toward the master-bus engine and holds it until that engine reports completion. A halt strap can keep the core in reset after the sequence ends. In that state both management-bus ports stay enabled, so software can reach the registers. The core-run enable rises only once any load has finished and the halt bit has been cleared through the slave port. The slave port is modelled here as a one-cycle clear pulse.

Top module: `boot_seq_ctrl`

## Requirements
- R1: Straps are sampled only on the first rising clock edge after `rst_n` goes high. Later changes on any strap pin leave every captured output unchanged until the next reset.
- R2: `slv_addr[6:0]` holds address bits 7..1. Bits 1, 2 and 3 come from `slv_strap[2:0]`, bit 5 from `slv_strap[3]`, bit 4 is 0, and bits 6 and 7 are 1. The expected value is {1,1,slv_strap[3],0,slv_strap[2:0]}.
- R3: `mst_addr[6:0]` holds address bits 7..1. Bits 1 to 4 come from `mst_strap[3:0]`, bit 5 is 1, bit 6 is 0 and bit 7 is 1. The expected value is {1,0,1,mst_strap[3:0]}.
- R4: `mst_slow` equals the captured `slow_strap`, where 1 means 100 kHz and 0 means 400 kHz. No input other than reset changes it.
- R5: With boot-mode code 1, `ld_req` is high from the capture edge onward and stays high until `ld_done` is sampled high.
- R6: With boot-mode code 0 and no halt, `ld_req` never rises and `core_run` rises on the second edge after release.
- R7: Codes 2 to 7 behave as code 0, and they set `mode_err`. `mode_err` stays set until the next reset, whatever the pins do.
- R8: With `halt_strap` captured high, `core_run` stays low while `smb_en` is high. A one-cycle `halt_clr` pulse makes `core_run` rise on the second edge after the pulse is sampled.
- R9: `core_run` never rises while a load is pending. Once high, it stays high until reset.
- R10: While `rst_n` is low, `ld_req`, `core_run`, `smb_en`, `mode_err`, `mst_slow` and both addresses are 0. This holds even when reset is asserted in the middle of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low fundamental reset, asynchronous assert |
| slv_strap | input | 4 | Slave address strap pins (bits 5,3,2,1) |
| mst_strap | input | 4 | EEPROM address strap pins (bits 4..1) |
| mode_strap | input | 3 | Boot-mode strap |
| halt_strap | input | 1 | Hold core in reset after the sequence |
| slow_strap | input | 1 | Master bus slow-speed strap |
| halt_clr | input | 1 | Halt-bit clear pulse from the slave port |
| ld_done | input | 1 | Configuration load finished |
| slv_addr | output | 7 | Slave address, bits 7..1 |
| mst_addr | output | 7 | EEPROM address, bits 7..1 |
| mst_slow | output | 1 | Master bus speed select |
| ld_req | output | 1 | Configuration load request |
| core_run | output | 1 | Core run enable |
| smb_en | output | 1 | Both management-bus ports enabled |
| mode_err | output | 1 | Sticky reserved boot-mode flag |

## Verification
A wrong sequencer state appears at the ports within one or two cycles of release. Either `core_run` comes early or late against the count from release, `halt_clr` or `ld_done`, or `ld_req` shows the wrong level right after the capture edge. A bad capture shows up as an address or speed value that differs from the arithmetic composition of the straps, or that moves when the pins are scrambled after release. The bench sweeps all address strap pairs and every boot-mode code with and without halt, so each fixed bit and each pin position is seen in both polarities.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [1:0] {
      ST_CAPT = 2'd0,
      ST_LOAD = 2'd1,
      ST_GATE = 2'd2,
      ST_RUN  = 2'd3
   } boot_st_t;

   // number of set bits of mask strictly below position pos
   function automatic int rank_below(input logic [31:0] mask, input int pos);
      int n;
      n = 0;
      for (int k = 0; k < 32; k++) begin
         if (k < pos && mask[k]) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/boot_addr_latch.sv
module boot_addr_latch #(
   parameter int                ADDR_W    = 7,
   parameter int                PIN_W     = 4,
   parameter logic [ADDR_W-1:0] PIN_MASK  = 7'b0010111,
   parameter logic [ADDR_W-1:0] FIXED_VAL = 7'b1100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [PIN_W-1:0]  pins,
   output logic [ADDR_W-1:0] addr
);
   localparam int MASK_ONES = $countones(PIN_MASK);

   if (MASK_ONES != PIN_W) begin : g_bad_mask
      $error("boot_addr_latch: PIN_MASK ones must equal PIN_W");
   end
   if (ADDR_W > 32) begin : g_bad_width
      $error("boot_addr_latch: ADDR_W above 32");
   end

   logic [ADDR_W-1:0] addr_d;
   logic [ADDR_W-1:0] addr_q;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (PIN_MASK[i]) begin : g_pin
         localparam int SRC = boot_seq_pkg::rank_below(32'(PIN_MASK), i);
         assign addr_d[i] = pins[SRC];
      end else begin : g_fix
         assign addr_d[i] = FIXED_VAL[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (cap_en) addr_q <= addr_d;
   end

   assign addr = addr_q;

   // R1: once the capture slot is over, the address never moves
   assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(addr_q));

endmodule

// File: rtl/boot_mode_decode.sv
module boot_mode_decode #(
   parameter int MODE_W      = 3,
   parameter int LOAD_CODE   = 1,
   parameter int NUM_DEFINED = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [MODE_W-1:0] mode_strap,
   output logic              load_sel,
   output logic              mode_err
);
   localparam int CODE_CNT = 1 << MODE_W;

   if (NUM_DEFINED > CODE_CNT || LOAD_CODE >= NUM_DEFINED) begin : g_bad_codes
      $error("boot_mode_decode: code range mismatch");
   end

   logic reserved;
   logic err_q;

   assign load_sel = (int'(mode_strap) == LOAD_CODE);
   assign reserved = (int'(mode_strap) >= NUM_DEFINED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else if (cap_en && reserved) err_q <= 1'b1;
   end

   assign mode_err = err_q;

   // R7: reserved-code flag is sticky until reset
   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   // R1: flag cannot rise outside the capture slot
   assert_err_only_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && !cap_en) |=> !err_q);

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
   import boot_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_sel,
   input  logic halt_strap,
   input  logic halt_clr,
   input  logic ld_done,
   output logic cap_en,
   output logic ld_req,
   output logic core_run,
   output logic smb_en
);
   boot_st_t st_q, st_d;
   logic     halt_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_CAPT: st_d = load_sel ? ST_LOAD : ST_GATE;
         ST_LOAD: if (ld_done) st_d = ST_GATE;
         ST_GATE: if (!halt_q) st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_CAPT;
         halt_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_CAPT) halt_q <= halt_strap;
         else if (halt_clr)   halt_q <= 1'b0;
      end
   end

   assign cap_en   = (st_q == ST_CAPT);
   assign ld_req   = (st_q == ST_LOAD);
   assign core_run = (st_q == ST_RUN);
   assign smb_en   = (st_q != ST_CAPT);

   // R9: run enable is sticky
   assert_run_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |=> core_run);
   // R8: running implies halt bit cleared
   assert_run_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |-> !halt_q);
   // R8: a set halt bit with no clear keeps the core stopped
   assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !halt_clr && !cap_en && !core_run) |=> !core_run);
   // R5: request held until done
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && !ld_done) |=> ld_req);
   // R9: run cannot follow a pending request directly
   assert_no_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |=> !core_run);

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl #(
   parameter int ADDR_W = 7,
   parameter int PIN_W  = 4,
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_W-1:0]  slv_strap,
   input  logic [PIN_W-1:0]  mst_strap,
   input  logic [MODE_W-1:0] mode_strap,
   input  logic              halt_strap,
   input  logic              slow_strap,
   input  logic              halt_clr,
   input  logic              ld_done,
   output logic [ADDR_W-1:0] slv_addr,
   output logic [ADDR_W-1:0] mst_addr,
   output logic              mst_slow,
   output logic              ld_req,
   output logic              core_run,
   output logic              smb_en,
   output logic              mode_err
);
   // address layouts, index 0 = address bit 1
   localparam logic [ADDR_W-1:0] SLV_MASK  = ADDR_W'(7'b0010111);
   localparam logic [ADDR_W-1:0] SLV_FIXED = ADDR_W'(7'b1100000);
   localparam logic [ADDR_W-1:0] MST_MASK  = ADDR_W'(7'b0001111);
   localparam logic [ADDR_W-1:0] MST_FIXED = ADDR_W'(7'b1010000);

   logic cap_en;
   logic load_sel;
   logic slow_q;

   boot_addr_latch #(.ADDR_W(ADDR_W), .PIN_W(PIN_W),
                     .PIN_MASK(SLV_MASK), .FIXED_VAL(SLV_FIXED)) u_slv (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pins(slv_strap), .addr(slv_addr));

   boot_addr_latch #(.ADDR_W(ADDR_W), .PIN_W(PIN_W),
                     .PIN_MASK(MST_MASK), .FIXED_VAL(MST_FIXED)) u_mst (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pins(mst_strap), .addr(mst_addr));

   boot_mode_decode #(.MODE_W(MODE_W), .LOAD_CODE(1), .NUM_DEFINED(2)) u_mode (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_strap(mode_strap),
      .load_sel(load_sel), .mode_err(mode_err));

   boot_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .load_sel(load_sel), .halt_strap(halt_strap),
      .halt_clr(halt_clr), .ld_done(ld_done), .cap_en(cap_en), .ld_req(ld_req),
      .core_run(core_run), .smb_en(smb_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slow_q <= 1'b0;
      else if (cap_en) slow_q <= slow_strap;
   end

   assign mst_slow = slow_q;

   // R4: speed select only changes in the capture slot
   assert_slow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(mst_slow));
   // R9: request and run never overlap
   assert_req_run_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_req && core_run));
   // R8: running implies both ports are enabled
   assert_run_ports_R8: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |-> smb_en);

endmodule

// File: tb/boot_seq_ctrl_test.sv
module boot_seq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] slv_strap = '0, mst_strap = '0;
   logic [2:0] mode_strap = '0;
   logic       halt_strap = 1'b0, slow_strap = 1'b0, halt_clr = 1'b0, ld_done = 1'b0;
   logic [6:0] slv_addr, mst_addr;
   logic       mst_slow, ld_req, core_run, smb_en, mode_err;
   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   boot_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .slv_strap(slv_strap), .mst_strap(mst_strap),
      .mode_strap(mode_strap), .halt_strap(halt_strap), .slow_strap(slow_strap),
      .halt_clr(halt_clr), .ld_done(ld_done), .slv_addr(slv_addr), .mst_addr(mst_addr),
      .mst_slow(mst_slow), .ld_req(ld_req), .core_run(core_run), .smb_en(smb_en),
      .mode_err(mode_err));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_slv(input int s);
      return (3 << 5) | (((s >> 3) & 1) << 4) | (s & 7);
   endfunction

   function automatic int exp_mst(input int m);
      return (5 << 4) | (m & 15);
   endfunction

   // reset, check idle outputs, release; returns just after the capture edge
   task automatic start(input int s, input int m, input int md, input bit h, input bit sl);
      @(negedge clk);
      rst_n = 1'b0; ld_done = 1'b0; halt_clr = 1'b0;
      slv_strap = 4'(s); mst_strap = 4'(m); mode_strap = 3'(md);
      halt_strap = h; slow_strap = sl;
      @(negedge clk);
      chk("R10 reset run",  int'(core_run), 0);
      chk("R10 reset req",  int'(ld_req), 0);
      chk("R10 reset ports", int'(smb_en), 0);
      chk("R10 reset err",  int'(mode_err), 0);
      chk("R10 reset addr", int'(slv_addr) + int'(mst_addr) + int'(mst_slow), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // scramble pins: they must be ignored from here on (R1)
      slv_strap = ~slv_strap; mst_strap = ~mst_strap;
      mode_strap = (md == 1) ? 3'd0 : 3'd1;
      halt_strap = ~h; slow_strap = ~sl;
   endtask

   initial begin
      // R2 R3 R4 R6 R1: sweep all address strap pairs
      for (int s = 0; s < 16; s++) begin
         for (int m = 0; m < 16; m++) begin
            start(s, m, 0, 1'b0, 1'(s ^ m));
            chk("R2 slave addr", int'(slv_addr), exp_slv(s));
            chk("R3 master addr", int'(mst_addr), exp_mst(m));
            chk("R4 slow", int'(mst_slow), (s ^ m) & 1);
            chk("R6 no req", int'(ld_req), 0);
            chk("R6 not yet run", int'(core_run), 0);
            @(negedge clk);
            chk("R6 run", int'(core_run), 1);
            chk("R1 slave hold", int'(slv_addr), exp_slv(s));
            chk("R1 master hold", int'(mst_addr), exp_mst(m));
            chk("R4 slow hold", int'(mst_slow), (s ^ m) & 1);
         end
      end
      // R5 R7 R8 R9: every mode code, with and without halt
      for (int md = 0; md < 8; md++) begin
         for (int h = 0; h < 2; h++) begin
            start(5, 10, md, 1'(h), 1'b0);
            chk("R5 req level", int'(ld_req), (md == 1) ? 1 : 0);
            chk("R7 err flag", int'(mode_err), (md >= 2) ? 1 : 0);
            chk("R8 ports on", int'(smb_en), 1);
            if (md == 1) begin
               for (int k = 0; k < 3; k++) begin
                  @(negedge clk);
                  chk("R5 req held", int'(ld_req), 1);
                  chk("R9 no run during load", int'(core_run), 0);
               end
               ld_done = 1'b1;
               @(negedge clk);
               ld_done = 1'b0;
               chk("R5 req dropped", int'(ld_req), 0);
               chk("R9 run after done", int'(core_run), 0);
            end
            if (h == 0) begin
               @(negedge clk);
               chk("R9 run", int'(core_run), 1);
            end else begin
               for (int k = 0; k < 3; k++) begin
                  @(negedge clk);
                  chk("R8 halted", int'(core_run), 0);
                  chk("R8 ports alive", int'(smb_en), 1);
               end
               halt_clr = 1'b1;
               @(negedge clk);
               halt_clr = 1'b0;
               chk("R8 one edge after clear", int'(core_run), 0);
               @(negedge clk);
               chk("R8 run after clear", int'(core_run), 1);
            end
            @(negedge clk);
            chk("R9 run sticky", int'(core_run), 1);
            chk("R7 err sticky", int'(mode_err), (md >= 2) ? 1 : 0);
         end
      end
      // R10: reset in the middle of a load
      start(0, 0, 1, 1'b0, 1'b1);
      chk("R5 load started", int'(ld_req), 1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R10 req cleared", int'(ld_req), 0);
      chk("R10 run cleared", int'(core_run), 0);
      chk("R10 slow cleared", int'(mst_slow), 0);
      @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule